// File: doc/BRIEF.md
# ADC Sample Min/Max and Threshold Monitor

The block watches two streams of 10-bit converter results, one for load current and one for supply voltage, each qualified by its own valid strobe. For each stream it holds the most recent sample together with the lowest and highest sample seen since reset. Every voltage sample is compared with two undervoltage levels (warning and critical) and two overvoltage levels (warning and critical). Every current sample is compared with a single overcurrent warning level. The five comparison results are driven as registered flag outputs.

Software or a bus bridge reaches all values through a byte-wide register port with an address, read strobe, write strobe and write data. Each 10-bit quantity is split into a high byte holding bits [9:2] and a low byte holding bits [1:0]. When the high byte of a monitored value is read, the low bits are captured, so the pair always describes one sample. A threshold that is written as two bytes takes effect only when its low byte is written. One further 8-bit read/write trim byte is kept for a neighbouring comparator.

Top module: `adc_watch`

## Requirements
- R1: After reset, every mapped register reads as follows. Latest values (0x00-0x03) and maxima (0x0A, 0x0B, 0x0E, 0x0F) read 0x00. Minima read 0xFF in the high byte (0x08, 0x0C) and 0x03 in the low byte (0x09, 0x0D). Undervoltage thresholds (0x1A-0x1D) read 0x00. Overvoltage and overcurrent thresholds (0x1E-0x23) read 0xFF high / 0x03 low. The trim byte at 0x2E reads 0xBF.
- R2: A current sample with cur_valid_i high replaces the latest current value at 0x00/0x01, and a voltage sample with vol_valid_i high replaces the latest voltage value at 0x02/0x03. The data inputs are ignored while their valid strobe is low.
- R3: The minimum of a stream (current at 0x08/0x09, voltage at 0x0C/0x0D) is replaced only by a valid sample that is strictly lower, so it never increases.
- R4: The maximum of a stream (current at 0x0A/0x0B, voltage at 0x0E/0x0F) is replaced only by a valid sample that is strictly higher, so it never decreases.
- R5: The even address of each pair returns bits [9:2]. The odd address returns bits [1:0] in data bits [1:0], with bits [7:2] zero.
- R6: A read of a monitored high byte (0x00, 0x02, 0x08, 0x0A, 0x0C, 0x0E) captures the matching low bits. A later read of the odd address returns those captured bits, even if new samples have arrived. Before any such read, the captured bits equal the pair's reset low bits.
- R7: A threshold pair is at base 0x1A + 2*k, with k = 0 for undervoltage warning, 1 for undervoltage critical, 2 for overvoltage warning, 3 for overvoltage critical and 4 for overcurrent warning. A write to the high byte is held in a staging register and changes neither the compared value nor the readback. A write to the low byte makes {staged high byte, wdata_i[1:0]} active.
- R8: On each valid voltage sample, uv_warn_o and uv_crit_o are set when the sample is strictly below the active warning or critical undervoltage threshold and cleared otherwise. They hold between samples.
- R9: On each valid sample, ov_warn_o and ov_crit_o (voltage) and oc_warn_o (current) are set when the sample is strictly above their active threshold and cleared otherwise. They hold between samples.
- R10: Reads of unmapped addresses return 0x00. Writes to read-only or unmapped addresses change nothing.
- R11: The trim byte at 0x2E stores all 8 written bits and reads them back.
- R12: rdata_o is loaded at the clock edge where rd_en_i is high and holds its value while rd_en_i is low. A read returns the register contents from before any sample or write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_valid_i | input | 1 | Current sample strobe |
| cur_data_i | input | 10 | Current sample |
| vol_valid_i | input | 1 | Voltage sample strobe |
| vol_data_i | input | 10 | Voltage sample |
| addr_i | input | 8 | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| uv_warn_o | output | 1 | Voltage below warning level |
| uv_crit_o | output | 1 | Voltage below critical level |
| ov_warn_o | output | 1 | Voltage above warning level |
| ov_crit_o | output | 1 | Voltage above critical level |
| oc_warn_o | output | 1 | Current above warning level |

## Verification
A sample strobed at clock edge N is visible in the latest, minimum and maximum registers and in the flags right after edge N. A read strobed at edge M presents its byte on rdata_o right after edge M. The bench drives every strobe for exactly one cycle from the falling edge and samples results at the next falling edge, half a period after the edge that loaded them. Threshold commits are therefore in place before the following sample is strobed. The snapshot check places a new sample between the high-byte and low-byte reads to separate the captured bits from the live ones.

// File: rtl/adc_watch_pkg.sv
package adc_watch_pkg;
  localparam int NUM_RO  = 6;
  localparam int NUM_THR = 5;
  localparam int THR_UV_WARN = 0;
  localparam int THR_UV_CRIT = 1;
  localparam int THR_OV_WARN = 2;
  localparam int THR_OV_CRIT = 3;
  localparam int THR_OC_WARN = 4;
  localparam logic [7:0] THR_BASE  = 8'h1A;
  localparam logic [7:0] TRIM_ADDR = 8'h2E;
  localparam logic [7:0] TRIM_RST  = 8'hBF;

  // high-byte address of each monitored pair
  function automatic logic [7:0] ro_addr(int i);
    case (i)
      0:       return 8'h00;
      1:       return 8'h02;
      2:       return 8'h08;
      3:       return 8'h0A;
      4:       return 8'h0C;
      default: return 8'h0E;
    endcase
  endfunction

  function automatic bit ro_is_min(int i);
    return (i == 2) || (i == 4);
  endfunction

  function automatic bit thr_is_under(int k);
    return k < 2;
  endfunction
endpackage

// File: rtl/adc_watch_track.sv
module adc_watch_track #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] last_o,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_o <= '0;
      min_o  <= '1;
      max_o  <= '0;
    end else if (valid_i) begin
      last_o <= data_i;
      if (data_i < min_o) min_o <= data_i;
      if (data_i > max_o) max_o <= data_i;
    end
  end
endmodule

// File: rtl/adc_watch_thr.sv
module adc_watch_thr #(
  parameter int           W   = 10,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] thr_o
);
  localparam int LO_W = W - 8;
  logic [7:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= RST[W-1:LO_W];
      thr_o   <= RST;
    end else begin
      if (wr_hi_i) stage_q <= wdata_i;
      // low-byte write commits the staged high byte
      if (wr_lo_i) thr_o <= {stage_q, wdata_i[LO_W-1:0]};
    end
  end
endmodule

// File: rtl/adc_watch.sv
module adc_watch
  import adc_watch_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cur_valid_i,
  input  logic [SAMPLE_W-1:0] cur_data_i,
  input  logic                vol_valid_i,
  input  logic [SAMPLE_W-1:0] vol_data_i,
  input  logic [7:0]          addr_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  output logic                uv_warn_o,
  output logic                uv_crit_o,
  output logic                ov_warn_o,
  output logic                ov_crit_o,
  output logic                oc_warn_o
);
  localparam int W    = SAMPLE_W;
  localparam int LO_W = W - 8;

  logic [1:0]                   valid_ch;
  logic [1:0][W-1:0]            data_ch, last_ch, min_ch, max_ch;
  logic [NUM_RO-1:0][W-1:0]     ro_val;
  logic [NUM_RO-1:0][LO_W-1:0]  snap_q;
  logic [NUM_THR-1:0][W-1:0]    thr_act;
  logic [7:0]                   trim_q;
  logic [7:0]                   rd_next;

  // channel 0 = current, 1 = voltage
  assign valid_ch = {vol_valid_i, cur_valid_i};
  assign data_ch  = {vol_data_i, cur_data_i};

  for (genvar c = 0; c < 2; c++) begin : g_trk
    adc_watch_track #(.W(W)) u_trk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_ch[c]),
      .data_i (data_ch[c]),
      .last_o (last_ch[c]),
      .min_o  (min_ch[c]),
      .max_o  (max_ch[c])
    );
  end

  assign ro_val[0] = last_ch[0];
  assign ro_val[1] = last_ch[1];
  assign ro_val[2] = min_ch[0];
  assign ro_val[3] = max_ch[0];
  assign ro_val[4] = min_ch[1];
  assign ro_val[5] = max_ch[1];

  for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
    localparam logic [7:0]   A_HI  = THR_BASE + 8'(2 * k);
    localparam logic [7:0]   A_LO  = A_HI + 8'd1;
    localparam logic [W-1:0] T_RST = thr_is_under(k) ? '0 : '1;
    adc_watch_thr #(.W(W), .RST(T_RST)) u_thr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_hi_i(wr_en_i && (addr_i == A_HI)),
      .wr_lo_i(wr_en_i && (addr_i == A_LO)),
      .wdata_i(wdata_i),
      .thr_o  (thr_act[k])
    );
  end

  for (genvar i = 0; i < NUM_RO; i++) begin : g_snap
    localparam logic [7:0]      A_HI  = ro_addr(i);
    localparam logic [LO_W-1:0] S_RST = ro_is_min(i) ? '1 : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          snap_q[i] <= S_RST;
      else if (rd_en_i && addr_i == A_HI)   snap_q[i] <= ro_val[i][LO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              trim_q <= TRIM_RST;
    else if (wr_en_i && addr_i == TRIM_ADDR)  trim_q <= wdata_i;
  end

  always_comb begin
    rd_next = 8'h00;
    for (int i = 0; i < NUM_RO; i++) begin
      if (addr_i == ro_addr(i))         rd_next = ro_val[i][W-1:LO_W];
      if (addr_i == ro_addr(i) + 8'd1)  rd_next = 8'(snap_q[i]);
    end
    for (int k = 0; k < NUM_THR; k++) begin
      if (addr_i == THR_BASE + 8'(2 * k))     rd_next = thr_act[k][W-1:LO_W];
      if (addr_i == THR_BASE + 8'(2 * k + 1)) rd_next = 8'(thr_act[k][LO_W-1:0]);
    end
    if (addr_i == TRIM_ADDR) rd_next = trim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= 8'h00;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uv_warn_o <= 1'b0;
      uv_crit_o <= 1'b0;
      ov_warn_o <= 1'b0;
      ov_crit_o <= 1'b0;
      oc_warn_o <= 1'b0;
    end else begin
      if (vol_valid_i) begin
        uv_warn_o <= vol_data_i < thr_act[THR_UV_WARN];
        uv_crit_o <= vol_data_i < thr_act[THR_UV_CRIT];
        ov_warn_o <= vol_data_i > thr_act[THR_OV_WARN];
        ov_crit_o <= vol_data_i > thr_act[THR_OV_CRIT];
      end
      if (cur_valid_i) oc_warn_o <= cur_data_i > thr_act[THR_OC_WARN];
    end
  end
endmodule

// File: rtl/adc_watch_chk.sv
module adc_watch_chk #(
  parameter int W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cur_valid_i,
  input logic [W-1:0]     cur_data_i,
  input logic             vol_valid_i,
  input logic [W-1:0]     vol_data_i,
  input logic [7:0]       addr_i,
  input logic             rd_en_i,
  input logic [7:0]       rdata_o,
  input logic             uv_warn_o,
  input logic             uv_crit_o,
  input logic             ov_warn_o,
  input logic             ov_crit_o,
  input logic             oc_warn_o,
  input logic [4:0][W-1:0] thr_act,
  input logic [W-1:0]     cur_min,
  input logic [W-1:0]     cur_max,
  input logic [W-1:0]     vol_min,
  input logic [W-1:0]     vol_max
);
  assert_min_monotone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_min <= $past(cur_min)) && (vol_min <= $past(vol_min)));

  assert_max_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_max >= $past(cur_max)) && (vol_max >= $past(vol_max)));

  assert_uv_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_valid_i |=> (uv_warn_o == ($past(vol_data_i) < $past(thr_act[0])))
                 && (uv_crit_o == ($past(vol_data_i) < $past(thr_act[1]))));

  assert_uv_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vol_valid_i |=> $stable(uv_warn_o) && $stable(uv_crit_o));

  assert_ov_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vol_valid_i |=> (ov_warn_o == ($past(vol_data_i) > $past(thr_act[2])))
                 && (ov_crit_o == ($past(vol_data_i) > $past(thr_act[3]))));

  assert_oc_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_i |=> (oc_warn_o == ($past(cur_data_i) > $past(thr_act[4]))));

  assert_unmapped_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ((addr_i >= 8'h10 && addr_i <= 8'h19) || addr_i >= 8'h2F)) |=> rdata_o == 8'h00);

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind adc_watch adc_watch_chk #(.W(SAMPLE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cur_valid_i(cur_valid_i),
  .cur_data_i (cur_data_i),
  .vol_valid_i(vol_valid_i),
  .vol_data_i (vol_data_i),
  .addr_i     (addr_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .uv_warn_o  (uv_warn_o),
  .uv_crit_o  (uv_crit_o),
  .ov_warn_o  (ov_warn_o),
  .ov_crit_o  (ov_crit_o),
  .oc_warn_o  (oc_warn_o),
  .thr_act    (thr_act),
  .cur_min    (min_ch[0]),
  .cur_max    (max_ch[0]),
  .vol_min    (min_ch[1]),
  .vol_max    (max_ch[1])
);

// File: tb/test_adc_watch.sv
module test_adc_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cur_valid = 1'b0, vol_valid = 1'b0;
  logic [9:0] cur_data = '0, vol_data = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] rdata;
  logic       uv_warn, uv_crit, ov_warn, ov_crit, oc_warn;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  adc_watch i_adc_watch (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_valid_i(cur_valid), .cur_data_i(cur_data),
    .vol_valid_i(vol_valid), .vol_data_i(vol_data),
    .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata),
    .uv_warn_o(uv_warn), .uv_crit_o(uv_crit), .ov_warn_o(ov_warn),
    .ov_crit_o(ov_crit), .oc_warn_o(oc_warn)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic samp_cur(input logic [9:0] d);
    @(negedge clk); cur_data = d; cur_valid = 1'b1;
    @(negedge clk); cur_valid = 1'b0;
  endtask

  task automatic samp_vol(input logic [9:0] d);
    @(negedge clk); vol_data = d; vol_valid = 1'b1;
    @(negedge clk); vol_valid = 1'b0;
  endtask

  task automatic chk_pair(string req, logic [7:0] a, logic [9:0] exp);
    logic [7:0] d;
    rd(a, d);        check(req, d, exp[9:2]);
    rd(a + 8'd1, d); check(req, d, {6'b0, exp[1:0]});
  endtask

  // {sample, expected min, expected max} for the current stream
  localparam logic [29:0] VEC [6] = '{
    {10'h155, 10'h155, 10'h155},
    {10'h200, 10'h155, 10'h200},
    {10'h100, 10'h100, 10'h200},
    {10'h100, 10'h100, 10'h200},
    {10'h3FF, 10'h100, 10'h3FF},
    {10'h001, 10'h001, 10'h3FF}
  };

  localparam logic [7:0] RST_ADDR [14] = '{8'h00, 8'h02, 8'h08, 8'h0A, 8'h0C, 8'h0E,
    8'h1A, 8'h1C, 8'h1E, 8'h20, 8'h22, 8'h03, 8'h09, 8'h2E};
  localparam logic [7:0] RST_EXP  [14] = '{8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00,
    8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h03, 8'hBF};

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 14; i++) begin
      rd(RST_ADDR[i], d);
      check("R1 reset value", d, RST_EXP[i]);
    end
    rd(8'h1F, d); check("R1 ov_warn low reset", d, 8'h03);
    check("R1 flags clear", {uv_warn, uv_crit, ov_warn, ov_crit, oc_warn}, 0);

    // R2 R3 R4 R5 vector table on current stream
    for (int i = 0; i < 6; i++) begin
      samp_cur(VEC[i][29:20]);
      chk_pair("R2 latest current", 8'h00, VEC[i][29:20]);
      chk_pair("R3 current min", 8'h08, VEC[i][19:10]);
      chk_pair("R4 current max", 8'h0A, VEC[i][9:0]);
    end

    // R2 data ignored without strobe
    @(negedge clk); cur_data = 10'h2AA; vol_data = 10'h2AA;
    repeat (2) @(negedge clk);
    chk_pair("R2 no strobe", 8'h00, 10'h001);

    // R10 RO write ignored, unmapped reads
    wr(8'h00, 8'h55); wr(8'h08, 8'h55);
    chk_pair("R10 RO write ignored", 8'h00, 10'h001);
    chk_pair("R10 RO min write ignored", 8'h08, 10'h001);
    rd(8'h10, d); check("R10 unmapped 0x10", d, 0);
    rd(8'h05, d); check("R10 unmapped 0x05", d, 0);
    rd(8'h2F, d); check("R10 unmapped 0x2F", d, 0);
    wr(8'h2F, 8'h77); rd(8'h2F, d); check("R10 unmapped write", d, 0);

    // R6 snapshot: 0x2FE -> hi 0xBF lo 2
    samp_vol(10'h2FE);
    rd(8'h02, d); check("R6 hi", d, 8'hBF);
    samp_vol(10'h001);
    rd(8'h03, d); check("R6 captured low", d, 8'h02);
    chk_pair("R6 fresh pair", 8'h02, 10'h001);
    chk_pair("R3 voltage min", 8'h0C, 10'h001);
    chk_pair("R4 voltage max", 8'h0E, 10'h2FE);

    // R7 R8 undervoltage warning 0x100
    wr(8'h1A, 8'h40);
    rd(8'h1A, d); check("R7 staged not active", d, 8'h00);
    samp_vol(10'h0FF); check("R7 staged not compared", uv_warn, 0);
    wr(8'h1B, 8'h00);
    chk_pair("R7 committed", 8'h1A, 10'h100);
    samp_vol(10'h0FF); check("R8 uv_warn below", uv_warn, 1);
    repeat (3) @(negedge clk); check("R8 uv_warn holds", uv_warn, 1);
    samp_vol(10'h100); check("R8 uv_warn equal clears", uv_warn, 0);

    // R8 critical 0x040
    wr(8'h1C, 8'h10); wr(8'h1D, 8'h00);
    samp_vol(10'h03F);
    check("R8 uv_crit below", uv_crit, 1);
    check("R8 uv_warn below", uv_warn, 1);

    // R9 overvoltage critical 0x200
    wr(8'h20, 8'h80); wr(8'h21, 8'h00);
    samp_vol(10'h201);
    check("R9 ov_crit above", ov_crit, 1);
    check("R9 ov_warn default", ov_warn, 0);
    samp_vol(10'h200); check("R9 ov_crit equal clears", ov_crit, 0);

    // R9 overcurrent 0x003 set by low byte only
    wr(8'h22, 8'h00); wr(8'h23, 8'h03);
    samp_cur(10'h004); check("R9 oc_warn above", oc_warn, 1);
    samp_vol(10'h3FF); check("R9 oc holds on voltage", oc_warn, 1);
    samp_cur(10'h003); check("R9 oc_warn equal clears", oc_warn, 0);

    // R11 trim byte
    wr(8'h2E, 8'h5A); rd(8'h2E, d); check("R11 trim", d, 8'h5A);

    // R12 hold and same-cycle ordering
    rd(8'h2E, d);
    repeat (3) @(negedge clk); check("R12 rdata holds", rdata, 8'h5A);
    @(negedge clk); addr = 8'h00; rd_en = 1'b1; cur_data = 10'h3FC; cur_valid = 1'b1;
    @(negedge clk); rd_en = 1'b0; cur_valid = 1'b0;
    check("R12 read before sample", rdata, 8'h00);
    rd(8'h00, d); check("R12 sample then visible", d, 8'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule